// File: doc/BRIEF.md
# Device Interface Power State Controller

This block tracks the interface state of a peripheral device that a host drives over a memory-mapped link. After reset it waits for an internal ready indication, then lets the host bring the device into the active state. A link inactivity timer drops the device by itself into a first idle state, and later into a deeper low-power state. The host can suspend the device and resume it by writing a target state code. The controller reports the current state code. It also reports whether host register access is open, whether channels may be started, whether low power is wanted, and whether the host has ever made an illegal request.

The host request is a single-cycle strobe (`req_valid`) with a 3-bit target code. It has no back-pressure: every strobe is decoded in the cycle it arrives. State codes are 0 for RESET, 1 for READY, 2 for M0 (active), 3 for M1 (idle), 4 for M2 (low power) and 5 for M3 (host suspended). Only target codes 2 and 5 can ever be legal.

Top module: `dev_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `state_code` is 0 and `mmio_en`, `chan_ok`, `lp_req` and `req_err` are 0. While the state is RESET, host requests are dropped without setting `req_err`.
- R2: In RESET, `core_ready` high moves the state to READY (1) at the next clock edge. `mmio_en` is 1 in every state except RESET.
- R3: In READY, a request with target code 2 moves the state to M0 (2) at the next edge.
- R4: `chan_ok` is 1 exactly when the state is M0.
- R5: In M0 with `idle_limit` = L > 0, L consecutive cycles without link activity and without a request move the state to M1 (3) at the edge that ends the L-th cycle. Any link activity restarts the count. L = 0 disables the move.
- R6: In M1, a cycle with `link_active` high and no request returns the state to M0 at the next edge.
- R7: In M1 with `deep_limit` = D > 0, D consecutive idle cycles without a request move the state to M2 (4). D = 0 disables the move. The count starts fresh each time M1 is entered.
- R8: A request with target 5 is legal from M0, M1 and M2 and enters M3 (5). A request with target 2 is legal from M1, M2 and M3 and enters M0.
- R9: `lp_req` is 1 exactly in M2 and M3.
- R10: Outside RESET, any other request leaves the state unchanged and sets `req_err`. `req_err` then stays 1 until reset.
- R11: A request cycle outside RESET takes priority over link activity and the timer. It also restarts the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_ready | input | 1 | Internal ready indication |
| req_valid | input | 1 | Host state-change request strobe |
| req_state | input | 3 | Requested target state code |
| link_active | input | 1 | Physical link activity seen this cycle |
| idle_limit | input | TW | Idle cycles in M0 before M1 (0 = off) |
| deep_limit | input | TW | Idle cycles in M1 before M2 (0 = off) |
| state_code | output | 3 | Current state code |
| mmio_en | output | 1 | Host register access allowed |
| chan_ok | output | 1 | Channel start allowed |
| lp_req | output | 1 | Low-power request |
| req_err | output | 1 | Sticky illegal-request flag |

## Verification
The hardest case to reach is an idle count that expires in exactly the cycle where a host request or link activity arrives. The chain M0, then M1, then M2 also needs two uninterrupted idle runs. The random stimulus keeps both limits small (0 to 6) and link activity sparse, so the timeouts fire often. The random requests sometimes land on the expiry cycle. Directed sequences then force each exact boundary: the cycle before expiry, the expiry cycle, a zero limit, and a request on the expiry cycle.

// File: rtl/dev_pwr_pkg.sv
`timescale 1ns/1ps
package dev_pwr_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PS_RESET = 3'd0,
    PS_READY = 3'd1,
    PS_M0    = 3'd2,
    PS_M1    = 3'd3,
    PS_M2    = 3'd4,
    PS_M3    = 3'd5
  } pstate_e;

  // Legal host transitions: wake to M0, or suspend to M3.
  function automatic logic req_legal(input pstate_e cur, input logic [CODE_W-1:0] tgt);
    case (tgt)
      3'd2:    return (cur == PS_READY) || (cur == PS_M1) || (cur == PS_M2) || (cur == PS_M3);
      3'd5:    return (cur == PS_M0) || (cur == PS_M1) || (cur == PS_M2);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dpc_req_dec.sv
`timescale 1ns/1ps
module dpc_req_dec
  import dev_pwr_pkg::*;
(
  input  pstate_e            cur,
  input  logic               req_valid,
  input  logic [CODE_W-1:0]  req_state,
  output logic               take,
  output logic               reject,
  output logic               seen
);
  logic open_win;
  logic ok;

  // Requests count only once the register space is open.
  assign open_win = req_valid && (cur != PS_RESET);
  assign ok       = req_legal(cur, req_state);
  assign seen     = open_win;
  assign take     = open_win && ok;
  assign reject   = open_win && !ok;
endmodule

// File: rtl/dpc_idle_timer.sv
`timescale 1ns/1ps
module dpc_idle_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          act,
  input  logic          clear,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;
  logic          armed;

  assign armed  = (limit != '0);
  assign expire = run && !act && armed && (cnt >= limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || !run || act || expire) begin
      cnt <= '0;
    end else if (armed) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dpc_fsm.sv
`timescale 1ns/1ps
module dpc_fsm
  import dev_pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_ready,
  input  logic               take,
  input  logic               reject,
  input  logic [CODE_W-1:0]  req_state,
  input  logic               link_active,
  input  logic               expire,
  output pstate_e            state,
  output logic               changing,
  output logic               err
);
  pstate_e nxt;

  always_comb begin
    nxt = state;
    if (state == PS_RESET) begin
      if (core_ready) nxt = PS_READY;
    end else if (take) begin
      nxt = pstate_e'(req_state);
    end else if (!reject) begin
      case (state)
        PS_M0:   if (expire) nxt = PS_M1;
        PS_M1: begin
          if (link_active)  nxt = PS_M0;
          else if (expire)  nxt = PS_M2;
        end
        default: nxt = state;
      endcase
    end
  end

  assign changing = (nxt != state);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PS_RESET;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      if (reject) err <= 1'b1;
    end
  end
endmodule

// File: rtl/dev_pwr_ctrl.sv
`timescale 1ns/1ps
module dev_pwr_ctrl
  import dev_pwr_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_ready,
  input  logic               req_valid,
  input  logic [CODE_W-1:0]  req_state,
  input  logic               link_active,
  input  logic [TW-1:0]      idle_limit,
  input  logic [TW-1:0]      deep_limit,
  output logic [CODE_W-1:0]  state_code,
  output logic               mmio_en,
  output logic               chan_ok,
  output logic               lp_req,
  output logic               req_err
);
  pstate_e       state;
  logic          take, reject, seen;
  logic          expire, changing;
  logic          run;
  logic [TW-1:0] cur_limit;

  dpc_req_dec u_dec (
    .cur       (state),
    .req_valid (req_valid),
    .req_state (req_state),
    .take      (take),
    .reject    (reject),
    .seen      (seen)
  );

  assign run       = (state == PS_M0) || (state == PS_M1);
  assign cur_limit = (state == PS_M0) ? idle_limit : deep_limit;

  dpc_idle_timer #(.TW(TW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .act    (link_active || seen),
    .clear  (changing),
    .limit  (cur_limit),
    .expire (expire)
  );

  dpc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_ready  (core_ready),
    .take        (take),
    .reject      (reject),
    .req_state   (req_state),
    .link_active (link_active),
    .expire      (expire),
    .state       (state),
    .changing    (changing),
    .err         (req_err)
  );

  assign state_code = state;
  assign mmio_en    = (state != PS_RESET);
  assign chan_ok    = (state == PS_M0);
  assign lp_req     = (state == PS_M2) || (state == PS_M3);
endmodule

// File: rtl/dev_pwr_ctrl_chk.sv
`timescale 1ns/1ps
module dev_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_state,
  input logic       link_active,
  input logic [2:0] state_code,
  input logic       req_err
);
  logic legal_req;
  assign legal_req = (req_state == 3'd2 && (state_code == 3'd1 || state_code == 3'd3 ||
                                            state_code == 3'd4 || state_code == 3'd5)) ||
                     (req_state == 3'd5 && (state_code == 3'd2 || state_code == 3'd3 ||
                                            state_code == 3'd4));

  p_rst_noerr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0 && !req_err) |=> !req_err);

  p_ready_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd1) |=> (state_code == 3'd1 || state_code == 3'd2));

  p_m1_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 3'd2 && state_code != 3'd3) |=> (state_code != 3'd3));

  p_m1_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd3 && link_active && !req_valid) |=> (state_code == 3'd2));

  p_m2_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 3'd3 && state_code != 3'd4) |=> (state_code != 3'd4 || $past(req_valid)));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> req_err);

  p_bad_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && state_code != 3'd0 && !legal_req) |=> ($stable(state_code) && req_err));
endmodule

bind dev_pwr_ctrl dev_pwr_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_state   (req_state),
  .link_active (link_active),
  .state_code  (state_code),
  .req_err     (req_err)
);

// File: tb/dev_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module dev_pwr_ctrl_tb;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_ready = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_state = '0;
  logic          link_active = 1'b0;
  logic [TW-1:0] idle_limit = '0;
  logic [TW-1:0] deep_limit = '0;
  logic [2:0]    state_code;
  logic          mmio_en, chan_ok, lp_req, req_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference model state
  int m_st = 0;
  int m_cnt = 0;
  bit m_err = 0;

  always #10 clk = ~clk;

  dev_pwr_ctrl #(.TW(TW)) u_dut (
    .clk (clk), .rst_n (rst_n), .core_ready (core_ready),
    .req_valid (req_valid), .req_state (req_state), .link_active (link_active),
    .idle_limit (idle_limit), .deep_limit (deep_limit),
    .state_code (state_code), .mmio_en (mmio_en), .chan_ok (chan_ok),
    .lp_req (lp_req), .req_err (req_err)
  );

  function automatic bit legal(int cur, int tgt);
    if (tgt == 2) return cur == 1 || cur == 3 || cur == 4 || cur == 5;
    if (tgt == 5) return cur == 2 || cur == 3 || cur == 4;
    return 0;
  endfunction

  // One clock edge of the requirement model (R1..R11).
  task automatic model_edge();
    int lim;
    int prev;
    prev = m_st;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_err = 0;
    end else if (m_st == 0) begin
      if (core_ready) m_st = 1;
    end else if (req_valid) begin
      if (legal(m_st, int'(req_state))) m_st = int'(req_state);
      else m_err = 1;
      m_cnt = 0;
    end else if (m_st == 2 || m_st == 3) begin
      lim = (m_st == 2) ? int'(idle_limit) : int'(deep_limit);
      if (link_active) begin
        m_cnt = 0;
        if (m_st == 3) m_st = 2;
      end else if (lim != 0 && m_cnt + 1 >= lim) begin
        m_st = (m_st == 2) ? 3 : 4;
      end else if (lim != 0) begin
        m_cnt++;
      end
    end
    if (m_st != prev || !(m_st == 2 || m_st == 3)) m_cnt = 0;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(int'(state_code) == m_st, "R3 R5 R6 R7 R8 R10 R11 state", int'(state_code), m_st);
    chk(mmio_en == (m_st != 0), "R2 mmio_en", int'(mmio_en), int'(m_st != 0));
    chk(chan_ok == (m_st == 2), "R4 chan_ok", int'(chan_ok), int'(m_st == 2));
    chk(lp_req == (m_st == 4 || m_st == 5), "R9 lp_req", int'(lp_req), int'(m_st == 4 || m_st == 5));
    chk(req_err == m_err, "R1 R10 req_err", int'(req_err), int'(m_err));
  endtask

  // Drive at the falling edge, model the rising edge, sample at the next falling edge.
  task automatic step(bit rst, bit rdy, bit lnk, bit rv, int rs);
    rst_n = rst; core_ready = rdy; link_active = lnk;
    req_valid = rv; req_state = 3'(rs);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    idle_limit = 16'd3; deep_limit = 16'd4;
    do_reset();
    chk(state_code == 3'd0 && !mmio_en && !lp_req && !req_err && !chan_ok,
        "R1 reset outputs", int'(state_code), 0);
    // R1: request in RESET dropped, no error
    step(1, 0, 0, 1, 7);
    chk(!req_err && state_code == 3'd0, "R1 request in RESET", int'(req_err), 0);
    // R2: ready
    step(1, 1, 0, 0, 0);
    chk(state_code == 3'd1 && mmio_en, "R2 enter READY", int'(state_code), 1);
    // R3 and R4
    step(1, 0, 1, 1, 2);
    chk(state_code == 3'd2 && chan_ok, "R3 R4 enter M0", int'(state_code), 2);
    // R5: L=3, activity restart, then exact boundary
    idle(2);
    step(1, 0, 1, 0, 0);
    idle(2);
    chk(state_code == 3'd2, "R5 before expiry", int'(state_code), 2);
    idle(1);
    chk(state_code == 3'd3, "R5 expiry to M1", int'(state_code), 3);
    // R6
    step(1, 0, 1, 0, 0);
    chk(state_code == 3'd2, "R6 wake to M0", int'(state_code), 2);
    // R7 and R9: M0 -> M1 (3) -> M2 (4)
    idle(3);
    idle(3);
    chk(state_code == 3'd3, "R7 before deep expiry", int'(state_code), 3);
    idle(1);
    chk(state_code == 3'd4 && lp_req, "R7 R9 enter M2", int'(state_code), 4);
    // R8: M2 -> M3 -> M0
    step(1, 0, 0, 1, 5);
    chk(state_code == 3'd5 && lp_req, "R8 R9 enter M3", int'(state_code), 5);
    step(1, 0, 0, 1, 2);
    chk(state_code == 3'd2 && !lp_req, "R8 resume M0", int'(state_code), 2);
    // R11: request on the expiry cycle
    idle(2);
    step(1, 0, 0, 1, 5);
    chk(state_code == 3'd5, "R11 request beats timer", int'(state_code), 5);
    step(1, 0, 0, 1, 2);
    // R10: illegal READY request in M0
    step(1, 0, 0, 1, 1);
    chk(state_code == 3'd2 && req_err, "R10 illegal holds state", int'(state_code), 2);
    idle(3);
    chk(req_err == 1'b1, "R10 error sticky", int'(req_err), 1);
    // R5: zero limit disables
    do_reset();
    step(1, 1, 0, 0, 0);
    idle_limit = 16'd0;
    step(1, 0, 0, 1, 2);
    idle(20);
    chk(state_code == 3'd2, "R5 zero limit", int'(state_code), 2);
    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      if ((i % 8) == 0) begin
        idle_limit = TW'($urandom_range(0, 6));
        deep_limit = TW'($urandom_range(0, 6));
      end
      r = $urandom_range(0, 99);
      step(!(r < 1), $urandom_range(0, 3) == 0, $urandom_range(0, 9) == 0,
           $urandom_range(0, 11) == 0,
           ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : (($urandom_range(0, 1) == 0) ? 2 : 5));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule